// File: doc/BRIEF.md
# Splittable 64/32-bit Up-Counting Timer

The block is a memory-mapped timer built around a 64-bit up-counter that can run either as one wide counter or as two independent 32-bit counters, the lower half and the upper half. Each half has its own counter register, its own period register and its own run-mode field. A global register releases each half from reset and picks the counter arrangement. A per-half interrupt pulses when the counter reaches its period.

Software uses a single-cycle 32-bit register bus. A write is taken on the clock edge where `we_i` is high. Read data is a combinational function of `addr_i`. In periodic mode with an all-ones period, a half serves as a free-running timebase. In one-shot mode, a half serves as an event timer that stops after one match.

Top module: `split_timer`

## Requirements
- R1: After reset, every register reads 0 and both interrupt outputs are low.
- R2: The byte offsets are fixed as follows. 0x10 is the lower counter and 0x14 the upper counter. 0x18 is the lower period and 0x1C the upper period. 0x20 is the run control register: the lower run mode sits in bits 7:6, the upper run mode in bits 23:22, and all other bits read 0. 0x24 is the global register: bit 0 releases the lower half, bit 1 releases the upper half, and bits 3:2 hold the arrangement, with all other bits reading 0. Any other offset reads 0 and ignores writes.
- R3: While a half's release bit is 0, its counter reads 0, writes to that counter are ignored, and the half raises no interrupt.
- R4: When the arrangement field is non-zero, the halves run independently. A released half whose run mode is 1 (one-shot) or 2 (periodic) adds one per cycle. Run mode 0 or 3 holds the counter at its value.
- R5: When an active half's counter equals its period at a clock edge, that half's interrupt output is high for the following cycle. A half in periodic mode reloads to 0 on that edge.
- R6: In one-shot mode, a match leaves the counter at the period value and clears the run mode to 0 on the same edge. A run control write on that edge takes precedence over the clear.
- R7: A bus write to a released counter takes precedence over counting and over reload on that edge.
- R8: When the arrangement field is 0, the two halves form one 64-bit counter. It is active only when both release bits are 1 and the lower run mode is 1 or 2. The lower half's carry increments the upper half. The compare uses both period registers. A match drives only the lower interrupt. The upper run mode has no effect, and the upper interrupt stays low.
- R9: A half in periodic mode with an all-ones period counts through 0xFFFFFFFF, wraps to 0 and pulses its interrupt at the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe, taken on the rising edge |
| addr_i | input | AW (8) | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_lo_o | output | 1 | Lower half (or 64-bit) match pulse |
| irq_hi_o | output | 1 | Upper half match pulse |

## Verification
The assertions take for granted that `we_i` and `addr_i` carry known values on every edge after reset. They also assume that any write on a match edge is visible as a counter or run control write, and they exclude such edges from the reload and clear properties. The stimulus issues at most one write per cycle and draws addresses mostly from the register map, with a few unmapped offsets. Periods are kept small, or set to all ones with counters preloaded near a wrap, so that matches, wraps and 64-bit carries occur within short runs.

// File: rtl/split_timer_pkg.sv
package split_timer_pkg;
  typedef enum logic [1:0] {
    RUN_OFF   = 2'd0,
    RUN_ONCE  = 2'd1,
    RUN_CYCLE = 2'd2,
    RUN_RSV   = 2'd3
  } run_mode_e;

  localparam logic [7:0] OFS_CNT_LO = 8'h10;
  localparam logic [7:0] OFS_CNT_HI = 8'h14;
  localparam logic [7:0] OFS_PRD_LO = 8'h18;
  localparam logic [7:0] OFS_PRD_HI = 8'h1C;
  localparam logic [7:0] OFS_RUN    = 8'h20;
  localparam logic [7:0] OFS_GLOBAL = 8'h24;

  localparam int RUN_LO_POS = 6;
  localparam int RUN_HI_POS = 22;
endpackage

// File: rtl/split_timer_half.sv
module split_timer_half #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rel_i,
  input  logic          run_i,
  input  logic          hit_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cnt_o
);
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!rel_i)  cnt_q <= '0;
    else if (wr_i)    cnt_q <= wdata_i;
    else if (run_i)   cnt_q <= hit_i ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R3
  held_in_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rel_i |=> cnt_o == '0);

  // R7
  write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i && wr_i) |=> cnt_o == $past(wdata_i));
endmodule

// File: rtl/split_timer_regs.sv
module split_timer_regs
  import split_timer_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          clr_lo_i,
  input  logic          clr_hi_i,
  input  logic [DW-1:0] cnt_lo_i,
  input  logic [DW-1:0] cnt_hi_i,
  output logic [DW-1:0] prd_lo_o,
  output logic [DW-1:0] prd_hi_o,
  output run_mode_e     run_lo_o,
  output run_mode_e     run_hi_o,
  output logic [1:0]    rel_o,
  output logic          dual_o,
  output logic [1:0]    cnt_wr_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] prd_lo_q, prd_hi_q;
  run_mode_e     run_lo_q, run_hi_q;
  logic [3:0]    glb_q;
  logic          run_wr;

  assign run_wr      = we_i && addr_i == AW'(OFS_RUN);
  assign cnt_wr_o[0] = we_i && addr_i == AW'(OFS_CNT_LO);
  assign cnt_wr_o[1] = we_i && addr_i == AW'(OFS_CNT_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prd_lo_q <= '0;
      prd_hi_q <= '0;
      glb_q    <= '0;
    end else if (we_i) begin
      if (addr_i == AW'(OFS_PRD_LO)) prd_lo_q <= wdata_i;
      if (addr_i == AW'(OFS_PRD_HI)) prd_hi_q <= wdata_i;
      if (addr_i == AW'(OFS_GLOBAL)) glb_q    <= wdata_i[3:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_lo_q <= RUN_OFF;
      run_hi_q <= RUN_OFF;
    end else if (run_wr) begin
      run_lo_q <= run_mode_e'(wdata_i[RUN_LO_POS +: 2]);
      run_hi_q <= run_mode_e'(wdata_i[RUN_HI_POS +: 2]);
    end else begin
      if (clr_lo_i) run_lo_q <= RUN_OFF;
      if (clr_hi_i) run_hi_q <= RUN_OFF;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AW'(OFS_CNT_LO): rdata_o = cnt_lo_i;
      AW'(OFS_CNT_HI): rdata_o = cnt_hi_i;
      AW'(OFS_PRD_LO): rdata_o = prd_lo_q;
      AW'(OFS_PRD_HI): rdata_o = prd_hi_q;
      AW'(OFS_RUN): begin
        rdata_o[RUN_LO_POS +: 2] = run_lo_q;
        rdata_o[RUN_HI_POS +: 2] = run_hi_q;
      end
      AW'(OFS_GLOBAL): rdata_o[3:0] = glb_q;
      default: rdata_o = '0;
    endcase
  end

  assign prd_lo_o = prd_lo_q;
  assign prd_hi_o = prd_hi_q;
  assign run_lo_o = run_lo_q;
  assign run_hi_o = run_hi_q;
  assign rel_o    = glb_q[1:0];
  assign dual_o   = glb_q[3:2] != 2'd0;

  // R6
  ctrl_write_beats_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_wr && clr_lo_i) |=> run_lo_o == run_mode_e'($past(wdata_i[RUN_LO_POS +: 2])));
endmodule

// File: rtl/split_timer.sv
module split_timer
  import split_timer_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_lo_o,
  output logic          irq_hi_o
);
  localparam int NH = 2;

  logic [DW-1:0] cnt  [NH];
  logic [DW-1:0] prd  [NH];
  run_mode_e     mode [NH];
  logic [NH-1:0] rel, cnt_wr, run, hit, clr, act, mt;
  logic          dual, act64, mt64, stop64;
  logic          irq_lo_d, irq_hi_d, irq_lo_q, irq_hi_q;

  split_timer_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .clr_lo_i (clr[0]),
    .clr_hi_i (clr[1]),
    .cnt_lo_i (cnt[0]),
    .cnt_hi_i (cnt[1]),
    .prd_lo_o (prd[0]),
    .prd_hi_o (prd[1]),
    .run_lo_o (mode[0]),
    .run_hi_o (mode[1]),
    .rel_o    (rel),
    .dual_o   (dual),
    .cnt_wr_o (cnt_wr),
    .rdata_o  (rdata_o)
  );

  for (genvar g = 0; g < NH; g++) begin : g_half
    assign act[g] = rel[g] && (mode[g] == RUN_ONCE || mode[g] == RUN_CYCLE);
    assign mt[g]  = cnt[g] == prd[g];

    split_timer_half #(.DW(DW)) u_half (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rel_i   (rel[g]),
      .run_i   (run[g]),
      .hit_i   (hit[g]),
      .wr_i    (cnt_wr[g]),
      .wdata_i (wdata_i),
      .cnt_o   (cnt[g])
    );
  end

  assign act64  = act[0] && rel[1];
  assign mt64   = mt[0] && mt[1];
  assign stop64 = mt64 && mode[0] == RUN_ONCE;

  always_comb begin
    if (dual) begin
      for (int h = 0; h < NH; h++) begin
        hit[h] = mt[h];
        clr[h] = act[h] && mt[h] && mode[h] == RUN_ONCE;
        run[h] = act[h] && !clr[h];
      end
      irq_lo_d = act[0] && mt[0];
      irq_hi_d = act[1] && mt[1];
    end else begin
      // lower carry feeds the upper half
      hit    = {mt64, mt64};
      clr    = {1'b0, act64 && stop64};
      run[0] = act64 && !stop64;
      run[1] = act64 && !stop64 && (mt64 || &cnt[0]);
      irq_lo_d = act64 && mt64;
      irq_hi_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_lo_q <= 1'b0;
      irq_hi_q <= 1'b0;
    end else begin
      irq_lo_q <= irq_lo_d;
      irq_hi_q <= irq_hi_d;
    end
  end

  assign irq_lo_o = irq_lo_q;
  assign irq_hi_o = irq_hi_q;

  // R8
  wide_mode_hi_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dual |=> !irq_hi_o);

  // R5
  periodic_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dual && act[0] && mt[0] && mode[0] == RUN_CYCLE && !cnt_wr[0] && rel[0])
      |=> cnt[0] == '0);

  // R5
  irq_follows_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dual && act[1] && mt[1]) |=> irq_hi_o);

  // R6
  oneshot_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dual && act[0] && mt[0] && mode[0] == RUN_ONCE && !(we_i && addr_i == AW'(OFS_RUN)))
      |=> mode[0] == RUN_OFF);

  // R4
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dual && act[1] && !mt[1] && !cnt_wr[1]) |=> cnt[1] == $past(cnt[1]) + 1'b1);

  // R8
  carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dual && act64 && !mt64 && &cnt[0] && !cnt_wr[0] && !cnt_wr[1])
      |=> cnt[0] == '0 && cnt[1] == $past(cnt[1]) + 1'b1);
endmodule

// File: tb/split_timer_test.sv
module split_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_lo, irq_hi;

  int    n_run = 0, n_fail = 0;
  string tag = "R1";
  bit    done = 1'b0;

  always #5 clk = ~clk;

  split_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_lo_o(irq_lo), .irq_hi_o(irq_hi)
  );

  // reference state
  logic [31:0] m_c0, m_c1, m_p0, m_p1;
  logic [1:0]  m_e0, m_e1;
  logic [3:0]  m_gc;
  logic        m_i0, m_i1;

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h10: return m_c0;
      8'h14: return m_c1;
      8'h18: return m_p0;
      8'h1C: return m_p1;
      8'h20: return {8'h0, m_e1, 14'h0, m_e0, 6'h0};
      8'h24: return {28'h0, m_gc};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic is_act(input logic r, input logic [1:0] e);
    return r && (e == 2'd1 || e == 2'd2);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_c0 <= '0; m_c1 <= '0; m_p0 <= '0; m_p1 <= '0;
      m_e0 <= '0; m_e1 <= '0; m_gc <= '0; m_i0 <= 1'b0; m_i1 <= 1'b0;
    end else begin : step
      logic [63:0] c64, n64;
      logic [31:0] nc0, nc1;
      logic [1:0]  ne0, ne1;
      logic        a0, a1, a64, mt0, mt1, mt64;
      nc0 = m_c0; nc1 = m_c1; ne0 = m_e0; ne1 = m_e1;
      if (m_gc[3:2] != 2'd0) begin
        a0 = is_act(m_gc[0], m_e0); mt0 = m_c0 == m_p0;
        a1 = is_act(m_gc[1], m_e1); mt1 = m_c1 == m_p1;
        if (a0) begin
          if (!mt0) nc0 = m_c0 + 1;
          else if (m_e0 == 2'd2) nc0 = '0;
          else ne0 = 2'd0;
        end
        if (a1) begin
          if (!mt1) nc1 = m_c1 + 1;
          else if (m_e1 == 2'd2) nc1 = '0;
          else ne1 = 2'd0;
        end
        m_i0 <= a0 && mt0;
        m_i1 <= a1 && mt1;
      end else begin
        a64  = is_act(m_gc[0], m_e0) && m_gc[1];
        c64  = {m_c1, m_c0};
        mt64 = c64 == {m_p1, m_p0};
        n64  = c64;
        if (a64) begin
          if (!mt64) n64 = c64 + 64'd1;
          else if (m_e0 == 2'd2) n64 = '0;
          else ne0 = 2'd0;
        end
        nc0 = n64[31:0]; nc1 = n64[63:32];
        m_i0 <= a64 && mt64;
        m_i1 <= 1'b0;
      end
      if (we) begin
        case (addr)
          8'h10: nc0 = wdata;
          8'h14: nc1 = wdata;
          8'h18: m_p0 <= wdata;
          8'h1C: m_p1 <= wdata;
          8'h20: begin ne0 = wdata[7:6]; ne1 = wdata[23:22]; end
          8'h24: m_gc <= wdata[3:0];
          default: ;
        endcase
      end
      if (!m_gc[0]) nc0 = '0;
      if (!m_gc[1]) nc1 = '0;
      m_c0 <= nc0; m_c1 <= nc1; m_e0 <= ne0; m_e1 <= ne1;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("rdata", rdata, exp_read(addr));
      chk("irq_lo", {31'h0, irq_lo}, {31'h0, m_i0});
      chk("irq_hi", {31'h0, irq_hi}, {31'h0, m_i1});
    end
  end

  task automatic drive(input logic w, input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    we = w; addr = a; wdata = d;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    drive(1'b1, a, d);
  endtask

  task automatic idle(input int n, input logic [7:0] a);
    for (int i = 0; i < n; i++) drive(1'b0, a, 32'h0);
  endtask

  function automatic logic [7:0] pick_addr();
    case ($urandom_range(0, 7))
      0: return 8'h10; 1: return 8'h14; 2: return 8'h18; 3: return 8'h1C;
      4: return 8'h20; 5: return 8'h24; 6: return 8'h28; default: return 8'h04;
    endcase
  endfunction

  function automatic logic [31:0] pick_data(input logic [7:0] a);
    case (a)
      8'h10, 8'h14: return ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFF0 + $urandom_range(0, 15)
                                                      : 32'($urandom_range(0, 12));
      8'h18, 8'h1C: return ($urandom_range(0, 4) == 0) ? 32'hFFFF_FFFF
                                                      : 32'($urandom_range(0, 15));
      8'h24: return {$urandom} | (($urandom_range(0, 3) != 0) ? 32'h3 : 32'h0);
      default: return $urandom;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    tag = "R1";
    for (int i = 0; i < 6; i++) idle(1, 8'h10 + 8'(4 * i));

    tag = "R2";
    wr(8'h20, 32'hFFFF_FFFF); wr(8'h24, 32'hFFFF_FFF0); wr(8'h28, 32'h1234_5678);
    idle(1, 8'h20); idle(1, 8'h24); idle(1, 8'h28); idle(1, 8'h00);

    tag = "R3";
    wr(8'h24, 32'h4); wr(8'h10, 32'h55); wr(8'h20, 32'h0080_0080);
    idle(4, 8'h10);

    tag = "R4";
    wr(8'h20, 32'h0); wr(8'h18, 32'd20); wr(8'h1C, 32'd20); wr(8'h24, 32'h7);
    wr(8'h20, 32'h0080_0080); idle(6, 8'h10); idle(3, 8'h14);
    wr(8'h20, 32'h00C0_0000); idle(4, 8'h10);

    tag = "R5";
    wr(8'h20, 32'h0); wr(8'h10, 32'd0); wr(8'h18, 32'd3); wr(8'h14, 32'd0); wr(8'h1C, 32'd5);
    wr(8'h20, 32'h0080_0080); idle(14, 8'h10);

    tag = "R6";
    wr(8'h20, 32'h0); wr(8'h10, 32'd0); wr(8'h20, 32'h0000_0040); idle(8, 8'h20);
    wr(8'h10, 32'd0); wr(8'h20, 32'h0000_0040); idle(2, 8'h10);
    wr(8'h20, 32'h0000_0040); idle(3, 8'h20);

    tag = "R7";
    wr(8'h20, 32'h0080_0080); wr(8'h10, 32'd1); wr(8'h14, 32'd2); idle(3, 8'h10);

    tag = "R9";
    wr(8'h20, 32'h0); wr(8'h18, 32'hFFFF_FFFF); wr(8'h10, 32'hFFFF_FFFC);
    wr(8'h20, 32'h0000_0080); idle(8, 8'h10);

    tag = "R8";
    wr(8'h20, 32'h0); wr(8'h24, 32'h3); wr(8'h18, 32'd2); wr(8'h1C, 32'd1);
    wr(8'h10, 32'hFFFF_FFFD); wr(8'h14, 32'd0); wr(8'h20, 32'h0000_0080);
    idle(4, 8'h14); idle(4, 8'h10);
    wr(8'h20, 32'h0); wr(8'h10, 32'hFFFF_FFFE); wr(8'h14, 32'd0); wr(8'h20, 32'h0000_0040);
    idle(6, 8'h10);

    tag = "R4";
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      a = pick_addr();
      if ($urandom_range(0, 3) == 0) wr(a, pick_data(a));
      else drive(1'b0, pick_addr(), 32'h0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule